// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Scheduler

This block decides when the memory controller has to stop normal traffic to keep SDRAM contents alive. A free-running interval counter, clocked by the system bus clock, raises a refresh request once per programmed period. The sequencer answers each request with a precharge to every enabled chip select, followed by a programmable group of auto-refresh commands. After every refresh it keeps activates blocked for a programmed recovery time. Software can also ask for a single precharge-all or a single auto-refresh, and it can toggle self-refresh with a one-cycle strobe.

While the memories sit in self-refresh, clock enable is held low, a status flag is raised, no command leaves the block and software requests are discarded. On exit the sequencer waits a NOP period that is a multiple of 16 cycles before it issues anything again. When block access is enabled, it also raises a transaction hold for (field+1)*16 cycles. A power mode drops clock enable for idle chip selects. A low-power flag reports whether any clock enable is currently low.

The commands leave the block as a registered request with a kind code and a chip-select mask. Address and data paths, the command bus itself and the initialisation sequence belong to the neighbouring blocks.

Top module: `sr_refresh_sched`

## Requirements
- R1: Synchronous active-high reset. Out of reset, cmd_valid=0, cmd_kind=0, cmd_cs=0, act_block=0, txn_hold=0, every cke bit is 1, stat_selfref=0 and stat_lowpower=0.
- R2: While cfg_ref_en=1 and the block is not in self-refresh, a timer refresh request arises every cfg_interval+1 cycles. Clearing cfg_ref_en resets the counter and discards a pending timer request.
- R3: A timer request produces one command with cmd_kind=1 (precharge-all), followed by exactly cfg_burst+1 commands with cmd_kind=2 (auto-refresh). The first refresh comes in the cycle right after the precharge. cmd_cs carries cfg_cs_en on every command and is 0 when cmd_valid=0.
- R4: After a refresh command in cycle t, no command is issued before cycle t+cfg_trc+2. act_block is high from t to t+cfg_trc+1, and during every command cycle.
- R5: A sw_precharge strobe yields one precharge-all, and a sw_refresh strobe yields one auto-refresh. Strobes that arrive while the sequencer is busy are held. When several requests are pending, the order of service is: self-refresh toggle, then precharge, then timer group, then software refresh.
- R6: A sw_sr_toggle strobe outside self-refresh issues cmd_kind=3 (self-refresh entry). From that same cycle on, stat_selfref=1 and all cke bits are 0.
- R7: While stat_selfref=1, no command other than the entry command appears, and sw_precharge and sw_refresh strobes are ignored. Requests pending at entry are discarded, and the interval counter restarts when self-refresh ends.
- R8: After self-refresh exit (a toggle while in self-refresh), no command is issued for E cycles, where E = 16*cfg_exit_nops and a field value of 0 means E = 16. A request already pending is issued in cycle E+1, counting the first cycle with stat_selfref=0 as cycle 0.
- R9: With cfg_block_access=1 at exit, txn_hold is high for exactly (cfg_exit_nops+1)*16 cycles, starting in the first cycle after exit. With cfg_block_access=0 it stays low.
- R10: With cfg_power_mode=1, cke[i] is 0 in any cycle where cs_idle[i] was 1 at the previous edge and no command or recovery gap is in progress. stat_lowpower is 1 exactly when at least one cke bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ref_en | input | 1 | Enables automatic refresh |
| cfg_interval | input | 18 | Refresh period minus one, in clocks |
| cfg_burst | input | 2 | Refresh commands per period minus one |
| cfg_trc | input | 4 | Recovery gap after a refresh, minus one |
| cfg_cs_en | input | 3 | Enabled chip selects |
| cfg_exit_nops | input | 5 | Self-refresh exit NOP count in units of 16 (0 = 16) |
| cfg_block_access | input | 1 | Hold transactions after self-refresh exit |
| cfg_power_mode | input | 1 | Drop clock enable on idle chip selects |
| cs_idle | input | 3 | Per chip-select idle indication |
| sw_precharge | input | 1 | Strobe: precharge all enabled chip selects |
| sw_refresh | input | 1 | Strobe: one auto-refresh to enabled chip selects |
| sw_sr_toggle | input | 1 | Strobe: toggle self-refresh |
| cmd_valid | output | 1 | A command request is presented this cycle |
| cmd_kind | output | 2 | 1 precharge-all, 2 auto-refresh, 3 self-refresh entry |
| cmd_cs | output | 3 | Chip-select mask of the command |
| act_block | output | 1 | Activates must not be issued |
| txn_hold | output | 1 | New transactions held after exit |
| cke | output | 3 | Per chip-select clock enable |
| stat_selfref | output | 1 | Memories are in self-refresh |
| stat_lowpower | output | 1 | At least one clock enable is low |

## Verification
The embedded properties watch, on every cycle, several rules that follow from the state alone:
- no command during self-refresh other than its entry, and clock enable low throughout it;
- silence while the exit NOP counter runs;
- a recovery gap with act_block high after each refresh;
- a refresh right behind a group's precharge;
- no back-to-back interval ticks;
- the low-power flag tracking clock enable.

The lengths of the interval, the recovery gap, the exit delay and the hold window, the number of refreshes in a group, the service order and the discarding of strobes in self-refresh all depend on timing and on the history of the inputs. Only the scenarios in the bench can show these, compared cycle by cycle against its reference model.

// File: rtl/sr_sched_pkg.sv
package sr_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE     = 2'd0,
    CMD_PRE_ALL  = 2'd1,
    CMD_REFRESH  = 2'd2,
    CMD_SR_ENTER = 2'd3
  } sr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_REF,
    ST_GAP,
    ST_SRE
  } seq_state_e;
endpackage

// File: rtl/sr_interval_timer.sv
module sr_interval_timer #(
  parameter int INT_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [INT_W-1:0] interval,
  output logic             tick
);
  logic [INT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == interval) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R2: ticks are spaced by the interval, never adjacent unless it is zero
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && interval != '0) |=> !tick);
endmodule

// File: rtl/sr_exit_timer.sv
module sr_exit_timer #(
  parameter int EXIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [EXIT_W-1:0] exit_nops,
  input  logic              block_access,
  output logic              nop_busy,
  output logic              hold
);
  localparam int CNT_W = EXIT_W + 5;

  logic [CNT_W-1:0] nop_cnt;
  logic [CNT_W-1:0] hold_cnt;
  logic [EXIT_W:0]  field_p1;
  logic [CNT_W-1:0] nop_len;
  logic [CNT_W-1:0] hold_len;

  always_comb begin
    field_p1 = {1'b0, exit_nops} + {{EXIT_W{1'b0}}, 1'b1};
    hold_len = {field_p1, 4'b0000};
    nop_len  = (exit_nops == '0) ? CNT_W'(16) : CNT_W'({exit_nops, 4'b0000});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nop_cnt  <= '0;
      hold_cnt <= '0;
      hold     <= 1'b0;
    end else if (load) begin
      nop_cnt  <= nop_len;
      hold_cnt <= block_access ? hold_len : '0;
      hold     <= block_access;
    end else begin
      if (nop_cnt != '0) nop_cnt <= nop_cnt - 1'b1;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      hold <= (hold_cnt > CNT_W'(1));
    end
  end

  assign nop_busy = (nop_cnt != '0);

  // R9: the hold window only starts at an exit
  a_r9_hold_starts_on_load: assert property (@(posedge clk) disable iff (rst)
    (!hold && !load) |=> !hold);
endmodule

// File: rtl/sr_cmd_seq.sv
module sr_cmd_seq
  import sr_sched_pkg::*;
#(
  parameter int NCS     = 3,
  parameter int BURST_W = 2,
  parameter int TRC_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_pre,
  input  logic               sw_ref,
  input  logic               sw_tog,
  input  logic               tick,
  input  logic               ref_en,
  input  logic [NCS-1:0]     cs_en,
  input  logic [BURST_W-1:0] burst,
  input  logic [TRC_W-1:0]   trc,
  input  logic               nop_busy,
  output logic               cmd_valid,
  output logic [1:0]         cmd_kind,
  output logic [NCS-1:0]     cmd_cs,
  output logic               act_block,
  output logic               selfref,
  output logic               sr_next,
  output logic               idle_next,
  output logic               exit_load
);
  seq_state_e         state, st_n;
  logic               grp, grp_n;
  logic [BURST_W-1:0] rem, rem_n;
  logic [TRC_W-1:0]   gap, gap_n;
  logic               pend_pre, pend_ref, pend_tick, pend_tog;
  logic               take_pre, take_ref, take_tick, take_tog, entering;
  sr_cmd_e            kind_n;

  always_comb begin
    st_n      = state;
    grp_n     = grp;
    rem_n     = rem;
    gap_n     = gap;
    sr_next   = selfref;
    exit_load = 1'b0;
    take_pre  = 1'b0;
    take_ref  = 1'b0;
    take_tick = 1'b0;
    take_tog  = 1'b0;
    entering  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (selfref) begin
          if (pend_tog) begin
            sr_next   = 1'b0;
            take_tog  = 1'b1;
            exit_load = 1'b1;
          end
        end else if (!nop_busy) begin
          if (pend_tog) begin
            st_n     = ST_SRE;
            sr_next  = 1'b1;
            take_tog = 1'b1;
            entering = 1'b1;
          end else if (pend_pre) begin
            st_n     = ST_PRE;
            grp_n    = 1'b0;
            take_pre = 1'b1;
          end else if (pend_tick) begin
            st_n      = ST_PRE;
            grp_n     = 1'b1;
            rem_n     = burst;
            take_tick = 1'b1;
          end else if (pend_ref) begin
            st_n     = ST_REF;
            rem_n    = '0;
            take_ref = 1'b1;
          end
        end
      end
      ST_PRE: st_n = grp ? ST_REF : ST_IDLE;
      ST_REF: begin
        st_n  = ST_GAP;
        gap_n = trc;
      end
      ST_GAP: begin
        if (gap == '0) begin
          if (rem != '0) begin
            st_n  = ST_REF;
            rem_n = rem - 1'b1;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          gap_n = gap - 1'b1;
        end
      end
      ST_SRE:  st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_n)
      ST_PRE:  kind_n = CMD_PRE_ALL;
      ST_REF:  kind_n = CMD_REFRESH;
      ST_SRE:  kind_n = CMD_SR_ENTER;
      default: kind_n = CMD_NONE;
    endcase
  end

  assign idle_next = (st_n == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      grp       <= 1'b0;
      rem       <= '0;
      gap       <= '0;
      selfref   <= 1'b0;
      pend_pre  <= 1'b0;
      pend_ref  <= 1'b0;
      pend_tick <= 1'b0;
      pend_tog  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_kind  <= CMD_NONE;
      cmd_cs    <= '0;
      act_block <= 1'b0;
    end else begin
      state     <= st_n;
      grp       <= grp_n;
      rem       <= rem_n;
      gap       <= gap_n;
      selfref   <= sr_next;
      pend_tog  <= (pend_tog & ~take_tog) | sw_tog;
      if (selfref || entering) begin
        pend_pre  <= 1'b0;
        pend_ref  <= 1'b0;
        pend_tick <= 1'b0;
      end else begin
        pend_pre  <= (pend_pre & ~take_pre) | sw_pre;
        pend_ref  <= (pend_ref & ~take_ref) | sw_ref;
        pend_tick <= ref_en & ((pend_tick & ~take_tick) | tick);
      end
      cmd_valid <= (kind_n != CMD_NONE);
      cmd_kind  <= kind_n;
      cmd_cs    <= (kind_n != CMD_NONE) ? cs_en : '0;
      act_block <= (st_n != ST_IDLE);
    end
  end

  // R4: a refresh is followed by a silent, activate-blocked cycle
  a_r4_gap_after_ref: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == CMD_REFRESH) |=> (!cmd_valid && act_block));

  // R3: a group precharge is followed at once by a refresh
  a_r3_group_ref_follows: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE && grp) |=> (cmd_valid && cmd_kind == CMD_REFRESH));
endmodule

// File: rtl/sr_refresh_sched.sv
module sr_refresh_sched
  import sr_sched_pkg::*;
#(
  parameter int NCS     = 3,
  parameter int INT_W   = 18,
  parameter int BURST_W = 2,
  parameter int TRC_W   = 4,
  parameter int EXIT_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_ref_en,
  input  logic [INT_W-1:0]   cfg_interval,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [TRC_W-1:0]   cfg_trc,
  input  logic [NCS-1:0]     cfg_cs_en,
  input  logic [EXIT_W-1:0]  cfg_exit_nops,
  input  logic               cfg_block_access,
  input  logic               cfg_power_mode,
  input  logic [NCS-1:0]     cs_idle,
  input  logic               sw_precharge,
  input  logic               sw_refresh,
  input  logic               sw_sr_toggle,
  output logic               cmd_valid,
  output logic [1:0]         cmd_kind,
  output logic [NCS-1:0]     cmd_cs,
  output logic               act_block,
  output logic               txn_hold,
  output logic [NCS-1:0]     cke,
  output logic               stat_selfref,
  output logic               stat_lowpower
);
  logic           tick;
  logic           nop_busy;
  logic           sr_next;
  logic           idle_next;
  logic           exit_load;
  logic [NCS-1:0] cke_n;

  sr_interval_timer #(.INT_W(INT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (cfg_ref_en & ~stat_selfref),
    .interval (cfg_interval),
    .tick     (tick)
  );

  sr_exit_timer #(.EXIT_W(EXIT_W)) u_exit (
    .clk          (clk),
    .rst          (rst),
    .load         (exit_load),
    .exit_nops    (cfg_exit_nops),
    .block_access (cfg_block_access),
    .nop_busy     (nop_busy),
    .hold         (txn_hold)
  );

  sr_cmd_seq #(.NCS(NCS), .BURST_W(BURST_W), .TRC_W(TRC_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .sw_pre    (sw_precharge),
    .sw_ref    (sw_refresh),
    .sw_tog    (sw_sr_toggle),
    .tick      (tick),
    .ref_en    (cfg_ref_en),
    .cs_en     (cfg_cs_en),
    .burst     (cfg_burst),
    .trc       (cfg_trc),
    .nop_busy  (nop_busy),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_cs    (cmd_cs),
    .act_block (act_block),
    .selfref   (stat_selfref),
    .sr_next   (sr_next),
    .idle_next (idle_next),
    .exit_load (exit_load)
  );

  generate
    for (genvar i = 0; i < NCS; i++) begin : g_cke
      assign cke_n[i] = ~sr_next & ~(cfg_power_mode & cs_idle[i] & idle_next);
      always_ff @(posedge clk) begin
        if (rst) cke[i] <= 1'b1;
        else     cke[i] <= cke_n[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stat_lowpower <= 1'b0;
    else     stat_lowpower <= ~&cke_n;
  end

  // R6: clock enable is low for every chip select while in self-refresh
  a_r6_cke_low_in_sr: assert property (@(posedge clk) disable iff (rst)
    stat_selfref |-> (cke == '0));

  // R7: only the entry command may appear while in self-refresh
  a_r7_quiet_in_sr: assert property (@(posedge clk) disable iff (rst)
    stat_selfref |-> (!cmd_valid || cmd_kind == CMD_SR_ENTER));

  // R8: no command while the exit NOP period runs
  a_r8_exit_quiet: assert property (@(posedge clk) disable iff (rst)
    nop_busy |-> !cmd_valid);

  // R10: low-power flag follows the clock enables
  a_r10_lowpower_mirror: assert property (@(posedge clk) disable iff (rst)
    stat_lowpower == ~&cke);
endmodule

// File: tb/sim_sr_refresh_sched.sv
module sim_sr_refresh_sched;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_ref_en = 1'b0;
  logic [17:0] cfg_interval = 18'd20;
  logic [1:0]  cfg_burst = 2'd0;
  logic [3:0]  cfg_trc = 4'd0;
  logic [2:0]  cfg_cs_en = 3'b111;
  logic [4:0]  cfg_exit_nops = 5'd0;
  logic        cfg_block_access = 1'b0;
  logic        cfg_power_mode = 1'b0;
  logic [2:0]  cs_idle = 3'b000;
  logic        sw_precharge = 1'b0;
  logic        sw_refresh = 1'b0;
  logic        sw_sr_toggle = 1'b0;
  logic        cmd_valid;
  logic [1:0]  cmd_kind;
  logic [2:0]  cmd_cs;
  logic        act_block;
  logic        txn_hold;
  logic [2:0]  cke;
  logic        stat_selfref;
  logic        stat_lowpower;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2 clk = ~clk;

  sr_refresh_sched u0 (
    .clk(clk), .rst(rst), .cfg_ref_en(cfg_ref_en), .cfg_interval(cfg_interval),
    .cfg_burst(cfg_burst), .cfg_trc(cfg_trc), .cfg_cs_en(cfg_cs_en),
    .cfg_exit_nops(cfg_exit_nops), .cfg_block_access(cfg_block_access),
    .cfg_power_mode(cfg_power_mode), .cs_idle(cs_idle), .sw_precharge(sw_precharge),
    .sw_refresh(sw_refresh), .sw_sr_toggle(sw_sr_toggle), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_cs(cmd_cs), .act_block(act_block), .txn_hold(txn_hold),
    .cke(cke), .stat_selfref(stat_selfref), .stat_lowpower(stat_lowpower)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 idle, 1 precharge, 2 refresh, 3 gap, 4 entry
  int m_phase, m_rem, m_gap, m_cnt, m_nop, m_hold;
  bit m_grp, m_tick, m_sr, m_holdq;
  bit p_pre, p_ref, p_tick, p_tog;
  int e_valid, e_kind, e_cs, e_act, e_cke, e_lp;

  always @(posedge clk) begin
    int  ph, rem, gp, cnt, nop, hold;
    bit  grp, tk, sr, hq, entering, leaving;
    bit  t_pre, t_ref, t_tick, t_tog;
    if (rst) begin
      m_phase = 0; m_rem = 0; m_gap = 0; m_cnt = 0; m_nop = 0; m_hold = 0;
      m_grp = 0; m_tick = 0; m_sr = 0; m_holdq = 0;
      p_pre = 0; p_ref = 0; p_tick = 0; p_tog = 0;
      e_valid = 0; e_kind = 0; e_cs = 0; e_act = 0; e_cke = 7; e_lp = 0;
    end else begin
      ph = m_phase; rem = m_rem; gp = m_gap; grp = m_grp; sr = m_sr;
      entering = 0; leaving = 0; t_pre = 0; t_ref = 0; t_tick = 0; t_tog = 0;
      case (m_phase)
        0: if (m_sr) begin
             if (p_tog) begin sr = 0; t_tog = 1; leaving = 1; end
           end else if (m_nop == 0) begin
             if (p_tog)       begin ph = 4; sr = 1; t_tog = 1; entering = 1; end
             else if (p_pre)  begin ph = 1; grp = 0; t_pre = 1; end
             else if (p_tick) begin ph = 1; grp = 1; rem = cfg_burst; t_tick = 1; end
             else if (p_ref)  begin ph = 2; rem = 0; t_ref = 1; end
           end
        1: ph = m_grp ? 2 : 0;
        2: begin ph = 3; gp = cfg_trc; end
        3: if (m_gap == 0) begin
             if (m_rem != 0) begin ph = 2; rem = m_rem - 1; end else ph = 0;
           end else gp = m_gap - 1;
        default: ph = 0;
      endcase
      if (!cfg_ref_en || m_sr) begin cnt = 0; tk = 0; end
      else if (m_cnt == int'(cfg_interval)) begin cnt = 0; tk = 1; end
      else begin cnt = m_cnt + 1; tk = 0; end
      if (leaving) begin
        nop  = (cfg_exit_nops == 0) ? 16 : 16 * int'(cfg_exit_nops);
        hold = cfg_block_access ? 16 * (int'(cfg_exit_nops) + 1) : 0;
        hq   = cfg_block_access;
      end else begin
        nop  = (m_nop > 0) ? m_nop - 1 : 0;
        hold = (m_hold > 0) ? m_hold - 1 : 0;
        hq   = (m_hold > 1);
      end
      p_tog = (p_tog && !t_tog) || sw_sr_toggle;
      if (m_sr || entering) begin
        p_pre = 0; p_ref = 0; p_tick = 0;
      end else begin
        p_pre  = (p_pre && !t_pre) || sw_precharge;
        p_ref  = (p_ref && !t_ref) || sw_refresh;
        p_tick = cfg_ref_en && ((p_tick && !t_tick) || m_tick);
      end
      m_phase = ph; m_rem = rem; m_gap = gp; m_grp = grp; m_sr = sr;
      m_cnt = cnt; m_tick = tk; m_nop = nop; m_hold = hold; m_holdq = hq;
      e_valid = (ph == 1 || ph == 2 || ph == 4) ? 1 : 0;
      e_kind  = (ph == 1) ? 1 : (ph == 2) ? 2 : (ph == 4) ? 3 : 0;
      e_cs    = e_valid ? int'(cfg_cs_en) : 0;
      e_act   = (ph != 0) ? 1 : 0;
      e_cke   = 0;
      for (int i = 0; i < 3; i++)
        if (!sr && !(cfg_power_mode && cs_idle[i] && ph == 0)) e_cke += (1 << i);
      e_lp = (e_cke != 7) ? 1 : 0;
    end
  end

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R3", "cmd_valid", int'(cmd_valid), e_valid);
      check("R5", "cmd_kind", int'(cmd_kind), e_kind);
      check("R3", "cmd_cs", int'(cmd_cs), e_cs);
      check("R4", "act_block", int'(act_block), e_act);
      check("R9", "txn_hold", int'(txn_hold), int'(m_holdq));
      check("R10", "cke", int'(cke), e_cke);
      check("R6", "stat_selfref", int'(stat_selfref), int'(m_sr));
      check("R10", "stat_lowpower", int'(stat_lowpower), e_lp);
    end
  end

  task automatic wait_kind(input int k, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(cmd_valid && int'(cmd_kind) == k) && n < 5000);
  endtask

  task automatic wait_any(output int k, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cmd_valid && n < 5000);
    k = int'(cmd_kind);
  endtask

  task automatic strobe(input bit pre, input bit rf, input bit tg);
    @(negedge clk);
    sw_precharge = pre; sw_refresh = rf; sw_sr_toggle = tg;
    @(negedge clk);
    sw_precharge = 0; sw_refresh = 0; sw_sr_toggle = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n, k, first, hcnt, quiet;
    idle(3);
    // R1: reset state
    check("R1", "cmd_valid", int'(cmd_valid), 0);
    check("R1", "cmd_kind", int'(cmd_kind), 0);
    check("R1", "act_block", int'(act_block), 0);
    check("R1", "txn_hold", int'(txn_hold), 0);
    check("R1", "cke", int'(cke), 7);
    check("R1", "stat_selfref", int'(stat_selfref), 0);
    check("R1", "stat_lowpower", int'(stat_lowpower), 0);
    rst = 0;

    // R2: timer period, one refresh per group
    cfg_cs_en = 3'b101; cfg_ref_en = 1;
    wait_kind(1, n);
    wait_kind(1, n);
    check("R2", "precharge spacing", n, 21);

    // R3 / R4: group of three refreshes with a four-cycle gap
    cfg_burst = 2; cfg_trc = 3;
    wait_kind(1, n);
    wait_kind(2, n);
    check("R3", "first refresh delay", n, 1);
    wait_kind(2, n);
    check("R4", "refresh spacing", n, 5);
    wait_kind(2, n);
    check("R4", "refresh spacing", n, 5);
    wait_any(k, n);
    check("R3", "group size (next cmd kind)", k, 1);

    // R2 / R5: refresh disabled, software strobes in the same cycle
    cfg_ref_en = 0; cfg_burst = 0; cfg_trc = 1;
    idle(30);
    strobe(1, 1, 0);
    wait_any(k, n);
    check("R5", "precharge served first", k, 1);
    wait_any(k, n);
    check("R5", "refresh served second", k, 2);
    strobe(0, 1, 0);
    strobe(1, 0, 0);
    idle(20);

    // R6 / R7 / R8 / R9: self-refresh, exit field 2 with hold
    cfg_ref_en = 1; cfg_exit_nops = 2; cfg_block_access = 1;
    strobe(0, 0, 1);
    wait_kind(3, n);
    check("R6", "stat_selfref at entry", int'(stat_selfref), 1);
    check("R6", "cke at entry", int'(cke), 0);
    quiet = 0;
    @(negedge clk);
    sw_precharge = 1; sw_refresh = 1;
    @(negedge clk);
    sw_precharge = 0; sw_refresh = 0;
    for (int i = 0; i < 40; i++) begin
      if (cmd_valid) quiet++;
      @(negedge clk);
    end
    check("R7", "commands during self-refresh", quiet, 0);
    strobe(0, 0, 1);
    while (stat_selfref) @(negedge clk);
    first = -1; hcnt = 0;
    for (int j = 0; j < 200; j++) begin
      sw_precharge = (j == 2);
      if (txn_hold) hcnt++;
      if (cmd_valid && first < 0) first = j;
      @(negedge clk);
    end
    sw_precharge = 0;
    check("R8", "first command after exit", first, 33);
    check("R9", "hold cycles", hcnt, 48);

    // R8 / R9: exit field 0 means 16, no hold
    cfg_exit_nops = 0; cfg_block_access = 0; cfg_ref_en = 0;
    idle(20);
    strobe(0, 0, 1);
    wait_kind(3, n);
    idle(10);
    strobe(0, 0, 1);
    while (stat_selfref) @(negedge clk);
    first = -1; hcnt = 0;
    for (int j = 0; j < 60; j++) begin
      sw_precharge = (j == 2);
      if (txn_hold) hcnt++;
      if (cmd_valid && first < 0) first = j;
      @(negedge clk);
    end
    sw_precharge = 0;
    check("R8", "first command after exit, field 0", first, 17);
    check("R9", "hold cycles without block access", hcnt, 0);

    // R10: power mode with idle chip selects
    cfg_power_mode = 1; cs_idle = 3'b011; cfg_ref_en = 1; cfg_interval = 12;
    idle(60);
    cfg_ref_en = 0;
    idle(30);
    check("R10", "cke with two idle", int'(cke), 4);
    check("R10", "stat_lowpower", int'(stat_lowpower), 1);
    cs_idle = 3'b000;
    idle(2);
    check("R10", "cke all busy", int'(cke), 7);
    check("R10", "stat_lowpower clear", int'(stat_lowpower), 0);
    idle(5);
    finish_run();
  end
endmodule